// File: doc/BRIEF.md
# Overload Restart and Fault Capture Controller

This controller handles protection events on a four-channel power output stage while it is running. Each channel has an overload flag from its protection circuit. When diagnosis is off, an overloaded channel is switched off by itself. It is polled on every millisecond tick and switched back on at the first tick where the overload has gone.

When diagnosis is on and the channel is armed, the overload is first confirmed at the next millisecond tick. A brief spike that has cleared by then returns the channel to service with nothing recorded. An overload that is still present starts a capture window of `DIAG_TICKS` ticks. During that window the short-to-ground, short-to-supply and shorted-load comparator flags are filtered for persistence. At the end, exactly one fault class is latched for the channel. The channel then falls back to plain restart behaviour and stays disarmed until the host completes a read, which is signalled by a one-cycle re-arm pulse. That pulse also clears the latched results, so faults that occur together are reported one at a time across successive read cycles.

The shorted-load decision uses one of two comparators. `line_mode` selects the low-impedance threshold for power-amplifier loads or the higher threshold for line-driver loads.

Top module: `sc_restart_ctrl`

## Requirements
- R1: After synchronous reset all channel enables are 1, all latched fault bits are 0, `cycle_done` is 0, and every channel is armed.
- R2: With `diag_en` = 0, an overload on an enabled channel drives its enable to 0 on the next clock. The channel stays off on every tick where its overload is still 1, and re-enables on the clock after the first tick where the overload is 0.
- R3: Channels are independent: an event on one channel never changes the enable or the latched bits of another.
- R4: With `diag_en` = 1 and the channel armed, an overload turns the channel off and waits for the next tick. If the overload is 0 at that tick, the channel re-enables and nothing is latched.
- R5: If the overload is still 1 at that tick, a capture window starts and ends on the `DIAG_TICKS`-th following tick. The result is latched at that tick, and the channel then continues with R2 restart behaviour.
- R6: A fault class is latched only if its flag was 1 on every clock of the capture window. If several classes qualify, only one is latched, with priority ground, then supply, then load, so at most one latched bit per channel is 1.
- R7: The load flag used in the window is `ld_hi[i]` (line-driver threshold) when `line_mode` = 1 and `ld_lo[i]` (power-amplifier threshold) when `line_mode` = 0.
- R8: A channel that has completed a capture is disarmed, and its later overloads take the R2 path. A `rearm` pulse re-arms all channels and clears latched bits and `cycle_done`. A capture that completes in the same clock takes precedence.
- R9: `cycle_done` becomes 1 on the clock after any channel completes a capture.
- R10: Dropping `diag_en` during confirmation or capture abandons it: no result is latched, and the channel continues with R2 restart behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| diag_en | input | 1 | Diagnosis enable |
| line_mode | input | 1 | 1 selects the line-driver load threshold |
| rearm | input | 1 | One-cycle pulse on completion of a host read |
| ovl | input | NCH | Overload flags per channel |
| sh_gnd | input | NCH | Short-to-ground comparator flags |
| sh_vs | input | NCH | Short-to-supply comparator flags |
| ld_lo | input | NCH | Shorted-load flag, power-amplifier threshold |
| ld_hi | input | NCH | Shorted-load flag, line-driver threshold |
| ch_en | output | NCH | Channel enables |
| q_gnd | output | NCH | Latched short-to-ground result |
| q_vs | output | NCH | Latched short-to-supply result |
| q_load | output | NCH | Latched shorted-load result |
| cycle_done | output | 1 | A capture has completed since the last re-arm |

## Verification
The bench drives the following patterns, each chosen to separate two outcomes:
- A held overload with diagnosis off separates tick-paced restart from immediate re-enable.
- A two-clock spike with diagnosis on separates the glitch filter from a full capture.
- Held overloads with one, several, or a mid-window-dropped class flag separate priority selection from persistence filtering.
- The same load fault under both threshold selections shows which comparator the window reads.
- A second overload before any re-arm separates a disarmed channel from one that captures again.
- Withdrawing diagnosis mid-window shows that no partial result is latched.

A behavioural model predicts every output on every clock.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONF = 2'd2,
    ST_CAPT = 2'd3
  } ch_state_t;
endpackage

// File: rtl/sc_fault_pick.sv
module sc_fault_pick (
  input  logic g_in,
  input  logic v_in,
  input  logic l_in,
  output logic g_out,
  output logic v_out,
  output logic l_out
);
  always_comb begin
    g_out = g_in;
    v_out = v_in & ~g_in;
    l_out = l_in & ~g_in & ~v_in;
  end
endmodule

// File: rtl/sc_chan.sv
module sc_chan
  import sc_pkg::*;
#(
  parameter int DIAG_TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic diag_en,
  input  logic line_mode,
  input  logic rearm,
  input  logic ovl,
  input  logic f_gnd,
  input  logic f_vs,
  input  logic f_lo,
  input  logic f_hi,
  output logic en_q,
  output logic q_gnd,
  output logic q_vs,
  output logic q_load,
  output logic cap_o
);
  localparam int CW = $clog2(DIAG_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DIAG_TICKS - 1);

  ch_state_t st, nxt;
  logic [CW-1:0] cnt;
  logic armed;
  logic acc_g, acc_v, acc_l;
  logic f_load, fin_g, fin_v, fin_l, pk_g, pk_v, pk_l;

  assign f_load = line_mode ? f_hi : f_lo;
  assign fin_g  = acc_g & f_gnd;
  assign fin_v  = acc_v & f_vs;
  assign fin_l  = acc_l & f_load;
  assign cap_o  = (st == ST_CAPT) && diag_en && ms_tick && (cnt == LAST);

  sc_fault_pick u_pick (
    .g_in(fin_g), .v_in(fin_v), .l_in(fin_l),
    .g_out(pk_g), .v_out(pk_v), .l_out(pk_l)
  );

  always_comb begin
    nxt = st;
    case (st)
      ST_RUN:  if (ovl) nxt = (diag_en && armed) ? ST_CONF : ST_WAIT;
      ST_WAIT: if (ms_tick && !ovl) nxt = ST_RUN;
      ST_CONF: begin
        if (!diag_en) nxt = ST_WAIT;
        else if (ms_tick) nxt = ovl ? ST_CAPT : ST_RUN;
      end
      ST_CAPT: begin
        if (!diag_en || cap_o) nxt = ST_WAIT;
      end
      default: nxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_RUN;
      en_q <= 1'b1;
      cnt <= '0;
      armed <= 1'b1;
      acc_g <= 1'b0;
      acc_v <= 1'b0;
      acc_l <= 1'b0;
      q_gnd <= 1'b0;
      q_vs <= 1'b0;
      q_load <= 1'b0;
    end else begin
      st <= nxt;
      en_q <= (nxt == ST_RUN);
      if (st == ST_CONF && nxt == ST_CAPT) begin
        cnt <= '0;
        acc_g <= f_gnd;
        acc_v <= f_vs;
        acc_l <= f_load;
      end else if (st == ST_CAPT) begin
        acc_g <= fin_g;
        acc_v <= fin_v;
        acc_l <= fin_l;
        if (ms_tick && !cap_o) cnt <= cnt + 1'b1;
      end
      if (cap_o) begin
        armed <= 1'b0;
        q_gnd <= pk_g;
        q_vs <= pk_v;
        q_load <= pk_l;
      end else if (rearm) begin
        armed <= 1'b1;
        q_gnd <= 1'b0;
        q_vs <= 1'b0;
        q_load <= 1'b0;
      end
    end
  end

  // R2: an overload on a running channel always switches it off
  p_ovl_drops_en_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && ovl) |=> !en_q);

  // R4: a cleared overload at the confirm tick restores the channel
  p_glitch_returns_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CONF && diag_en && ms_tick && !ovl) |=> en_q);

  // R5: latched bits appear only at the end of a capture window
  p_latch_at_end_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(q_gnd | q_vs | q_load) |-> $past(st == ST_CAPT));

  // R6: at most one fault class latched per channel
  p_single_class_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({q_gnd, q_vs, q_load}));

  // R10: diagnosis withdrawn mid-window leaves channel waiting
  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CAPT && !diag_en) |=> (st == ST_WAIT && !en_q));
endmodule

// File: rtl/sc_restart_ctrl.sv
module sc_restart_ctrl #(
  parameter int NCH        = 4,
  parameter int DIAG_TICKS = 100
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ms_tick,
  input  logic           diag_en,
  input  logic           line_mode,
  input  logic           rearm,
  input  logic [NCH-1:0] ovl,
  input  logic [NCH-1:0] sh_gnd,
  input  logic [NCH-1:0] sh_vs,
  input  logic [NCH-1:0] ld_lo,
  input  logic [NCH-1:0] ld_hi,
  output logic [NCH-1:0] ch_en,
  output logic [NCH-1:0] q_gnd,
  output logic [NCH-1:0] q_vs,
  output logic [NCH-1:0] q_load,
  output logic           cycle_done
);
  logic [NCH-1:0] cap;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    sc_chan #(.DIAG_TICKS(DIAG_TICKS)) u_ch (
      .clk(clk), .rst(rst), .ms_tick(ms_tick), .diag_en(diag_en),
      .line_mode(line_mode), .rearm(rearm), .ovl(ovl[i]),
      .f_gnd(sh_gnd[i]), .f_vs(sh_vs[i]), .f_lo(ld_lo[i]), .f_hi(ld_hi[i]),
      .en_q(ch_en[i]), .q_gnd(q_gnd[i]), .q_vs(q_vs[i]), .q_load(q_load[i]),
      .cap_o(cap[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) cycle_done <= 1'b0;
    else if (|cap) cycle_done <= 1'b1;
    else if (rearm) cycle_done <= 1'b0;
  end

  // R9: the done flag rises only after a channel completed a capture
  p_done_source_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(cycle_done) |-> $past(|cap));

  // R8: a re-arm with no concurrent capture clears the done flag
  p_rearm_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (rearm && !(|cap)) |=> !cycle_done);
endmodule

// File: tb/sim_sc_restart_ctrl.sv
module sim_sc_restart_ctrl;
  localparam int NCH = 4;
  localparam int DT  = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0, diag_en = 1'b0, line_mode = 1'b0, rearm = 1'b0;
  logic [NCH-1:0] ovl = '0, sh_gnd = '0, sh_vs = '0, ld_lo = '0, ld_hi = '0;
  logic [NCH-1:0] ch_en, q_gnd, q_vs, q_load;
  logic cycle_done;

  int checks = 0, errors = 0;
  bit done_run = 0;

  int md[NCH], cn[NCH];
  bit arm[NCH], ag[NCH], av[NCH], al[NCH];
  bit m_en[NCH], m_g[NCH], m_v[NCH], m_l[NCH];
  bit m_done;

  sc_restart_ctrl #(.NCH(NCH), .DIAG_TICKS(DT)) u0 (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .diag_en(diag_en),
    .line_mode(line_mode), .rearm(rearm), .ovl(ovl), .sh_gnd(sh_gnd),
    .sh_vs(sh_vs), .ld_lo(ld_lo), .ld_hi(ld_hi), .ch_en(ch_en),
    .q_gnd(q_gnd), .q_vs(q_vs), .q_load(q_load), .cycle_done(cycle_done)
  );

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      for (int k = 0; k < 4; k++) @(negedge clk);
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  end

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    bit anycap, capn, ld, fg, fv, fl;
    anycap = 0;
    for (int i = 0; i < NCH; i++) begin
      if (rst) begin
        md[i] = 0; cn[i] = 0; arm[i] = 1; m_en[i] = 1;
        m_g[i] = 0; m_v[i] = 0; m_l[i] = 0;
      end else begin
        ld = line_mode ? ld_hi[i] : ld_lo[i];
        capn = (md[i] == 3) && diag_en && ms_tick && (cn[i] == DT - 1);
        if (md[i] == 0) begin
          if (ovl[i]) md[i] = (diag_en && arm[i]) ? 2 : 1;
        end else if (md[i] == 1) begin
          if (ms_tick && !ovl[i]) md[i] = 0;
        end else if (md[i] == 2) begin
          if (!diag_en) md[i] = 1;
          else if (ms_tick) begin
            if (ovl[i]) begin
              md[i] = 3; cn[i] = 0; ag[i] = sh_gnd[i]; av[i] = sh_vs[i]; al[i] = ld;
            end else md[i] = 0;
          end
        end else begin
          if (!diag_en) md[i] = 1;
          else begin
            fg = ag[i] & sh_gnd[i]; fv = av[i] & sh_vs[i]; fl = al[i] & ld;
            ag[i] = fg; av[i] = fv; al[i] = fl;
            if (capn) begin
              m_g[i] = fg; m_v[i] = fv & !fg; m_l[i] = fl & !fg & !fv;
              md[i] = 1;
            end else if (ms_tick) cn[i] = cn[i] + 1;
          end
        end
        if (capn) begin arm[i] = 0; anycap = 1; end
        else if (rearm) begin arm[i] = 1; m_g[i] = 0; m_v[i] = 0; m_l[i] = 0; end
        m_en[i] = (md[i] == 0);
      end
    end
    if (rst) m_done = 0;
    else if (anycap) m_done = 1;
    else if (rearm) m_done = 0;
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NCH; i++) begin
        checks++;
        if (ch_en[i] !== m_en[i]) begin
          errors++;
          $display("FAIL R2 ch%0d enable actual %b expected %b t=%0t", i, ch_en[i], m_en[i], $time);
        end
        checks++;
        if ({q_gnd[i], q_vs[i], q_load[i]} !== {m_g[i], m_v[i], m_l[i]}) begin
          errors++;
          $display("FAIL R6 ch%0d latched actual %b%b%b expected %b%b%b", i,
                   q_gnd[i], q_vs[i], q_load[i], m_g[i], m_v[i], m_l[i]);
        end
      end
      checks++;
      if (cycle_done !== m_done) begin
        errors++;
        $display("FAIL R9 done actual %b expected %b", cycle_done, m_done);
      end
    end
  end

  task automatic expect_v(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_rearm;
    rearm = 1'b1; @(negedge clk); rearm = 1'b0;
  endtask

  initial begin
    clocks(3);
    rst = 1'b0;
    @(negedge clk);
    // R1
    expect_v("R1 en", 32'(ch_en), 32'hF);
    expect_v("R1 faults", 32'({q_gnd, q_vs, q_load}), 32'h0);
    expect_v("R1 done", 32'(cycle_done), 32'h0);

    // R2, R3: diagnosis off
    ovl[0] = 1'b1; clocks(2);
    expect_v("R2 off", 32'(ch_en), 32'hE);
    expect_v("R3 others", 32'(ch_en[3:1]), 32'h7);
    clocks(12);
    expect_v("R2 held off", 32'(ch_en), 32'hE);
    ovl[0] = 1'b0; clocks(12);
    expect_v("R2 restart", 32'(ch_en), 32'hF);

    // R4: spike filtered
    diag_en = 1'b1;
    ovl[1] = 1'b1; clocks(2); ovl[1] = 1'b0; clocks(15);
    expect_v("R4 en", 32'(ch_en), 32'hF);
    expect_v("R4 nothing", 32'({q_gnd, q_vs, q_load, cycle_done}), 32'h0);

    // R5, R9: held ground short on ch2
    sh_gnd[2] = 1'b1; ovl[2] = 1'b1; clocks(520);
    expect_v("R5 gnd", 32'(q_gnd), 32'h4);
    expect_v("R9 done", 32'(cycle_done), 32'h1);
    expect_v("R5 off", 32'(ch_en), 32'hB);
    ovl[2] = 1'b0; sh_gnd[2] = 1'b0; clocks(12);
    expect_v("R5 restart", 32'(ch_en), 32'hF);

    // R8: disarmed channel does not capture again
    sh_vs[2] = 1'b1; ovl[2] = 1'b1; clocks(520);
    expect_v("R8 no recapture", 32'({q_gnd, q_vs}), 32'h40);
    ovl[2] = 1'b0; sh_vs[2] = 1'b0; clocks(12);
    pulse_rearm; clocks(1);
    expect_v("R8 cleared", 32'({q_gnd, q_vs, q_load, cycle_done}), 32'h0);

    // R6: priority among several persistent faults, then next class
    sh_gnd[3] = 1'b1; sh_vs[3] = 1'b1; ld_lo[3] = 1'b1; ovl[3] = 1'b1; clocks(520);
    expect_v("R6 first gnd", 32'({q_gnd[3], q_vs[3], q_load[3]}), 32'h4);
    ovl[3] = 1'b0; sh_gnd[3] = 1'b0; clocks(12);
    pulse_rearm; clocks(2);
    ovl[3] = 1'b1; clocks(520);
    expect_v("R6 next vs", 32'({q_gnd[3], q_vs[3], q_load[3]}), 32'h2);
    ovl[3] = 1'b0; sh_vs[3] = 1'b0; ld_lo[3] = 1'b0; clocks(12);
    pulse_rearm; clocks(2);

    // R6: persistence, vs dropped mid-window
    sh_vs[0] = 1'b1; ld_lo[0] = 1'b1; ovl[0] = 1'b1; clocks(100);
    sh_vs[0] = 1'b0; clocks(420);
    expect_v("R6 persist", 32'({q_gnd[0], q_vs[0], q_load[0]}), 32'h1);
    ovl[0] = 1'b0; ld_lo[0] = 1'b0; clocks(12);
    pulse_rearm; clocks(2);

    // R7: threshold selection
    ld_hi[1] = 1'b1; ovl[1] = 1'b1; clocks(520);
    expect_v("R7 pa mode", 32'(q_load[1]), 32'h0);
    expect_v("R7 done", 32'(cycle_done), 32'h1);
    ovl[1] = 1'b0; clocks(12);
    pulse_rearm; clocks(2);
    line_mode = 1'b1; ovl[1] = 1'b1; clocks(520);
    expect_v("R7 line mode", 32'(q_load[1]), 32'h1);
    ovl[1] = 1'b0; ld_hi[1] = 1'b0; line_mode = 1'b0; clocks(12);
    pulse_rearm; clocks(2);

    // R10: withdrawing diagnosis mid-window
    sh_gnd[0] = 1'b1; ovl[0] = 1'b1; clocks(40);
    diag_en = 1'b0; clocks(600);
    expect_v("R10 nothing", 32'({q_gnd, cycle_done}), 32'h0);
    expect_v("R10 off", 32'(ch_en), 32'hE);
    ovl[0] = 1'b0; sh_gnd[0] = 1'b0; clocks(12);
    expect_v("R10 restart", 32'(ch_en), 32'hF);

    done_run = 1;
  end

  initial begin
    for (int k = 0; k < 150000; k++) begin
      @(negedge clk);
      if (done_run) break;
    end
    if (!done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule